// File: doc/BRIEF.md
# Two-Clock Registered Block Memory

This block is a 2048-bit storage array with one write port and one read port. A parameter sets its shape, which is one of 16, 8, 4, 2 or 1 bits per word. The number of words and the width of the address follow from that choice. Every input is registered on an input clock: write data, both addresses, write enable and read enable. Read data comes out through a register on a separate output clock. Each of the two register groups has its own clock enable, so either side can be stalled without the other. One active-low clear empties every register at once and leaves the array contents alone.

A write lands in the array on the input clock edge after the one that captured it. The strobe for that write is formed from the registered write enable and a flag recording that the capture really happened. When a read and a write to the same address are captured on the same edge, the read returns the word as it was before the write. A parameter selects single-port operation, in which the registered write address also serves as the read address.

Top module: `dual_clk_ram`

## Requirements
- R1: `WIDTH` may be 16, 8, 4, 2 or 1. The array then holds 2048/`WIDTH` words, and both addresses are log2(2048/`WIDTH`) bits wide.
- R2: Suppose `wr_en` and `in_clken` are both high at an `in_clk` edge. The data and address captured at that edge are then written on the next `in_clk` edge, and a later read of that address returns the data.
- R3: While `in_clken` is low at an `in_clk` edge, every input register keeps its value, and no write is started by that edge.
- R4: On an `out_clk` edge with `out_clken` high, `rd_data` loads the word at the registered read address, but only if the registered read enable is 1. If the registered read enable is 0, `rd_data` holds.
- R5: While `out_clken` is low at an `out_clk` edge, `rd_data` holds its value.
- R6: A read and a write to the same address captured on the same input edge: the read returns the word as it was before the write.
- R7: With `SINGLE_PORT`=1, reads use the registered write address and `rd_addr` has no effect.
- R8: A low `clr_n` forces `rd_data` to 0 at once. It cancels a write that was captured but has not yet landed, and it leaves the array contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| in_clk | input | 1 | Clock for all input registers and the array write |
| in_clken | input | 1 | Clock enable for the input registers |
| out_clk | input | 1 | Clock for the read data register |
| out_clken | input | 1 | Clock enable for the read data register |
| clr_n | input | 1 | Asynchronous clear, active low |
| wr_en | input | 1 | Write request |
| rd_en | input | 1 | Read request |
| wr_addr | input | AW | Write address; in single-port mode also the read address |
| rd_addr | input | AW | Read address; ignored in single-port mode |
| wr_data | input | WIDTH | Write data |
| rd_data | output | WIDTH | Registered read data |

## Verification
The hardest case to reach is a clear that arrives while a write is pending. That window lies between the capture edge and the commit edge, so it is less than one input clock period long. The bench captures a write and drops `clr_n` on the falling edge that follows. It holds the clear across the next rising edge, then reads the target address back and finds the old word. Read-during-write is reached in a similar way: a read and a write to one address are driven in the same cycle.

// File: rtl/dual_clk_ram.sv
module dual_clk_ram #(
  parameter int WIDTH = 8,
  parameter bit SINGLE_PORT = 1'b0,
  localparam int DEPTH = 2048 / WIDTH,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             in_clk,
  input  logic             in_clken,
  input  logic             out_clk,
  input  logic             out_clken,
  input  logic             clr_n,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [AW-1:0]    rd_addr,
  input  logic [WIDTH-1:0] wr_data,
  output logic [WIDTH-1:0] rd_data
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wa_q, ra_q;
  logic [WIDTH-1:0] d_q;
  logic             we_q, re_q, cap_q;
  logic             wr_strobe;
  logic [AW-1:0]    ra_eff;

  always_ff @(posedge in_clk or negedge clr_n) begin
    if (!clr_n) begin
      wa_q <= '0;
      ra_q <= '0;
      d_q  <= '0;
      we_q <= 1'b0;
      re_q <= 1'b0;
    end else if (in_clken) begin
      wa_q <= wr_addr;
      ra_q <= rd_addr;
      d_q  <= wr_data;
      we_q <= wr_en;
      re_q <= rd_en;
    end
  end

  // pulse generator: one strobe per real capture of a write
  always_ff @(posedge in_clk or negedge clr_n) begin
    if (!clr_n) cap_q <= 1'b0;
    else        cap_q <= in_clken;
  end

  assign wr_strobe = we_q & cap_q;
  assign ra_eff    = SINGLE_PORT ? wa_q : ra_q;

  always_ff @(posedge in_clk) begin
    if (wr_strobe) mem[wa_q] <= d_q;
  end

  always_ff @(posedge out_clk or negedge clr_n) begin
    if (!clr_n)                 rd_data <= '0;
    else if (out_clken && re_q) rd_data <= mem[ra_eff];
  end
endmodule

module dual_clk_ram_chk #(
  parameter int W = 8,
  parameter int AW = 8
) (
  input logic          in_clk,
  input logic          out_clk,
  input logic          clr_n,
  input logic          in_clken,
  input logic          out_clken,
  input logic          wr_en,
  input logic          re_q,
  input logic          wr_strobe,
  input logic [AW-1:0] wa_q,
  input logic [W-1:0]  d_q,
  input logic [W-1:0]  rd_data
);
  p_hold_inputs_r3: assert property (@(posedge in_clk) disable iff (!clr_n)
    !in_clken |=> ($stable(wa_q) && $stable(d_q)));

  p_strobe_from_capture_r2: assert property (@(posedge in_clk) disable iff (!clr_n)
    wr_strobe |-> ($past(in_clken) && $past(wr_en)));

  p_no_read_hold_r4: assert property (@(posedge out_clk) disable iff (!clr_n)
    !re_q |=> $stable(rd_data));

  p_out_stall_r5: assert property (@(posedge out_clk) disable iff (!clr_n)
    !out_clken |=> $stable(rd_data));
endmodule

bind dual_clk_ram dual_clk_ram_chk #(.W(WIDTH), .AW(AW)) u_chk (
  .in_clk(in_clk), .out_clk(out_clk), .clr_n(clr_n), .in_clken(in_clken),
  .out_clken(out_clken), .wr_en(wr_en), .re_q(re_q), .wr_strobe(wr_strobe),
  .wa_q(wa_q), .d_q(d_q), .rd_data(rd_data)
);

// File: tb/dual_clk_ram_tb.sv
module dual_clk_ram_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic clr_n;
  int n_chk = 0, n_fail = 0;

  // dual-port instance: 256 x 8
  logic       ci, co, we, re;
  logic [7:0] wa, ra, wd, rq;
  // single-port instance: 512 x 4
  logic       s_we, s_re;
  logic [8:0] s_wa, s_ra;
  logic [3:0] s_wd, s_rq;

  dual_clk_ram #(.WIDTH(8), .SINGLE_PORT(1'b0)) u_dut (
    .in_clk(clk), .in_clken(ci), .out_clk(clk), .out_clken(co), .clr_n(clr_n),
    .wr_en(we), .rd_en(re), .wr_addr(wa), .rd_addr(ra), .wr_data(wd), .rd_data(rq));

  dual_clk_ram #(.WIDTH(4), .SINGLE_PORT(1'b1)) u_dut_sp (
    .in_clk(clk), .in_clken(1'b1), .out_clk(clk), .out_clken(1'b1), .clr_n(clr_n),
    .wr_en(s_we), .rd_en(s_re), .wr_addr(s_wa), .rd_addr(s_ra), .wr_data(s_wd), .rd_data(s_rq));

  function automatic logic [7:0] fd(int a);
    return 8'((a * 37 + 5) & 8'hFF);
  endfunction
  function automatic logic [3:0] fs(int a);
    return 4'((a * 7 + 3) & 4'hF);
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic dp_write(int a, int d);
    @(negedge clk); we = 1'b1; wa = 8'(a); wd = 8'(d);
    @(negedge clk); we = 1'b0;
  endtask

  task automatic dp_read(int a, output logic [7:0] d);
    @(negedge clk); re = 1'b1; ra = 8'(a);
    @(negedge clk); re = 1'b0;
    @(negedge clk); d = rq;
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] v;
    clr_n = 1'b0; ci = 1'b1; co = 1'b1; we = 1'b0; re = 1'b0;
    wa = '0; ra = '0; wd = '0;
    s_we = 1'b0; s_re = 1'b0; s_wa = '0; s_ra = '0; s_wd = '0;
    repeat (3) @(negedge clk);
    check("R8 reset rd_data", rq, 0);
    check("R8 reset sp rd_data", s_rq, 0);
    clr_n = 1'b1;

    // R1 R2: full sweep, 256 x 8 shape
    for (int a = 0; a < 256; a++) dp_write(a, fd(a));
    for (int a = 0; a < 256; a++) begin
      dp_read(a, v);
      check("R2 R1 write/read sweep", v, fd(a));
    end

    // R4: registered read enable low holds the output
    dp_read(1, v);
    @(negedge clk); ra = 8'd2;
    @(negedge clk); @(negedge clk);
    check("R4 hold without read", rq, fd(1));

    // R5: output enable low holds the output
    @(negedge clk); re = 1'b1; ra = 8'd3; co = 1'b0;
    @(negedge clk); re = 1'b0;
    @(negedge clk);
    check("R5 hold with out_clken low", rq, fd(1));
    co = 1'b1;

    // R3: a write attempt while in_clken is low is not performed
    @(negedge clk); we = 1'b1; wa = 8'd30; wd = 8'hAA;
    @(negedge clk); wa = 8'd31; wd = 8'hBB; ci = 1'b0;
    @(negedge clk); we = 1'b0; ci = 1'b1;
    dp_read(30, v); check("R3 captured write lands", v, 8'hAA);
    dp_read(31, v); check("R3 stalled write dropped", v, fd(31));

    // R6: same-address read and write in one cycle returns old data
    @(negedge clk); we = 1'b1; wa = 8'd10; wd = 8'h5A; re = 1'b1; ra = 8'd10;
    @(negedge clk); we = 1'b0; re = 1'b0;
    @(negedge clk);
    check("R6 read-during-write old", rq, fd(10));
    dp_read(10, v); check("R6 new data after", v, 8'h5A);

    // R8: clear during a pending write
    dp_read(21, v);
    @(negedge clk); we = 1'b1; wa = 8'd20; wd = 8'h55;
    @(negedge clk); we = 1'b0;
    #1 clr_n = 1'b0;
    #1 check("R8 clear zeroes rd_data", rq, 0);
    @(negedge clk); clr_n = 1'b1;
    check("R8 rd_data stays zero", rq, 0);
    dp_read(20, v); check("R8 pending write cancelled", v, fd(20));
    dp_read(21, v); check("R8 array kept", v, fd(21));

    // R7 R1: single-port, 512 x 4, rd_addr driven with garbage
    for (int a = 0; a < 512; a++) begin
      @(negedge clk); s_we = 1'b1; s_wa = 9'(a); s_wd = fs(a); s_ra = 9'(a ^ 9'h155);
      @(negedge clk); s_we = 1'b0;
    end
    for (int a = 0; a < 512; a++) begin
      @(negedge clk); s_re = 1'b1; s_wa = 9'(a); s_ra = 9'(a ^ 9'h0AA);
      @(negedge clk); s_re = 1'b0; s_ra = 9'(a + 1);
      @(negedge clk);
      check("R7 single-port read", s_rq, fs(a));
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule